// File: doc/BRIEF.md
# ATA Device Task-File Register Interface

This block is the device end of an ATA/IDE register interface, the way a solid-state disk target presents itself on an 8-bit host bus. The host selects it with two active-low chip selects and a 3-bit register address, and strobes reads and writes synchronously to the block clock. The primary select opens the eight task-file registers. The secondary select opens the alternate-status and device-control pair. One address can name different registers for reads and for writes. The block drives its data outputs only during a selected read. When it is not driving, the enable output tells the pad logic to hold the bus at high impedance.

The block keeps the geometry and LBA registers, the features and error bytes, and the status flags BSY, RDY, DRQ and ERR. It samples its master/slave role only while reset is applied. Transfers start 16 bits wide and switch to bytes only after the host issues a Set Features command with the byte-mode feature code. A read-sector or write-sector command holds BSY until an external completion pulse arrives. DRQ then opens a one-sector window, served from an internal sector-buffer stub. The window closes after a full sector of accesses at the current width.

Top module: `ata_taskfile_dev`

## Requirements
- R1: `dataOe` is high only while `rdStb` is high and at least one chip select is low. With both chip selects high it stays low, whatever the strobes do.
- R2: With `csPriN` low, addresses 2, 3, 4, 5 and 6 are read/write registers that return the last byte written in `dataOut[7:0]`, with the upper byte zero. These are sector count, LBA 7:0, LBA 15:8, LBA 23:16 and drive/head. After reset all of them read 00h.
- R3: Primary address 1 reads the error byte and writes the features byte, so a features write leaves the error readback unchanged. Primary address 7 reads status and writes the command byte.
- R4: The status byte is laid out as BSY=bit 7, RDY=bit 6, DRQ=bit 3 and ERR=bit 0, and reads 40h after reset. `busyLed` follows BSY. BSY and DRQ are never set together.
- R5: `slaveSel` is captured only while `rstN` is low. A command write is accepted only if drive/head bit 4 equals the captured role (1 = slave). Otherwise it has no effect on status, error or `intrq`.
- R6: After reset, data accesses are 16 bits wide. An accepted command EFh with the features byte at 01h completes at once: no BSY, ERR clear, interrupt pending set. From then on data accesses are bytes in `dataOut[7:0]` with `dataOut[15:8]` = 0.
- R7: Any command code other than 20h, 30h, or EFh-with-features-01h sets ERR, loads 04h into the error byte and raises the interrupt-pending flag. The next good command clears ERR and the error byte.
- R8: Command 20h (read sector) or 30h (write sector) sets BSY. A `cmdDone` pulse while BSY is set clears BSY, sets DRQ and sets the interrupt-pending flag on the next edge.
- R9: DRQ stays set for exactly 512 byte accesses or 256 word accesses to primary address 0. The buffer is byte-addressed so that byte 2k is the low half and byte 2k+1 the high half of word k.
- R10: A read of primary address 7 clears the interrupt-pending flag, but a read of secondary address 6 (alternate status, same value) does not. `intrq` is the pending flag gated off by device-control bit 1, which is written at secondary address 6.
- R11: A command write while BSY or DRQ is set is ignored.
- R12: Primary address 0 read while DRQ is clear returns 0000h and leaves status unchanged. Secondary addresses other than 6 read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset |
| csPriN | input | 1 | Active-low select of the task-file bank |
| csSecN | input | 1 | Active-low select of the control bank |
| regAddr | input | 3 | Register address |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe, captured on the rising edge |
| dataIn | input | 16 | Host write data |
| dataOut | output | 16 | Read data |
| dataOe | output | 1 | High when the block drives the bus |
| slaveSel | input | 1 | Role jumper, 1 = slave, sampled in reset |
| cmdDone | input | 1 | Completion pulse from the command engine |
| intrq | output | 1 | Masked interrupt request |
| busyLed | output | 1 | Activity indicator, high while BSY |

## Verification
The bench builds the block with its default sector size of 512 bytes and 16-bit bus. This keeps the DRQ window at its true length in both widths, so the last-access boundary is checked in both widths. It also means a sector written as words can be read back as bytes, which checks the lane ordering. Two resets with different role inputs exercise role capture and the return to 16-bit mode, and the sector buffer is not cleared between them.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam logic [2:0] A_DATA    = 3'd0;
  localparam logic [2:0] A_ERRFEAT = 3'd1;
  localparam logic [2:0] A_SCNT    = 3'd2;
  localparam logic [2:0] A_LBA0    = 3'd3;
  localparam logic [2:0] A_LBA1    = 3'd4;
  localparam logic [2:0] A_LBA2    = 3'd5;
  localparam logic [2:0] A_DRVHD   = 3'd6;
  localparam logic [2:0] A_STATCMD = 3'd7;
  localparam logic [2:0] A_ALTCTL  = 3'd6;

  localparam logic [7:0] CMD_SETFEAT = 8'hEF;
  localparam logic [7:0] CMD_RDSEC   = 8'h20;
  localparam logic [7:0] CMD_WRSEC   = 8'h30;
  localparam logic [7:0] FEAT_BYTE   = 8'h01;
  localparam logic [7:0] ERR_ABORT   = 8'h04;

  typedef enum logic [2:0] {
    RD_NONE, RD_ZERO, RD_DATA, RD_ERROR, RD_TASK, RD_STATUS
  } rdSrc_t;

  typedef struct packed {
    logic   wrFeat;
    logic   wrSecCnt;
    logic   wrLba0;
    logic   wrLba1;
    logic   wrLba2;
    logic   wrDrvHd;
    logic   wrDevCtl;
    logic   bufWr;
    logic   errClear;
    logic   errAbort;
    rdSrc_t rdSrc;
  } tfStrobe_t;

endpackage

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csPriN,
  input  logic             csSecN,
  input  logic [2:0]       regAddr,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [7:0]       cmdByte,
  input  logic             slaveSel,
  input  logic             cmdDone,
  input  logic [7:0]       featVal,
  input  logic             drvHdSlave,
  output tfStrobe_t        strobe,
  output logic [7:0]       statusByte,
  output logic             byteMode,
  output logic [IDX_W-1:0] xferCnt,
  output logic             intPend
);

  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(SECTOR_BYTES / 2 - 1);

  logic bsy, drq, err, roleSlave;
  logic priSel, secSel;
  logic cmdWr, cmdAccept, isXfer, isByteFeat, badCmd;
  logic dataAcc, lastAcc, statusRd;

  assign priSel = !csPriN;
  assign secSel = csPriN && !csSecN;

  assign cmdWr      = priSel && wrStb && (regAddr == A_STATCMD);
  assign cmdAccept  = cmdWr && !bsy && !drq && (drvHdSlave == roleSlave);
  assign isXfer     = (cmdByte == CMD_RDSEC) || (cmdByte == CMD_WRSEC);
  assign isByteFeat = (cmdByte == CMD_SETFEAT) && (featVal == FEAT_BYTE);
  assign badCmd     = !isXfer && !isByteFeat;

  assign dataAcc  = priSel && (regAddr == A_DATA) && (rdStb || wrStb) && drq;
  assign lastAcc  = byteMode ? (xferCnt == LAST_BYTE) : (xferCnt == LAST_WORD);
  assign statusRd = priSel && rdStb && (regAddr == A_STATCMD);

  always_comb begin
    strobe = '0;
    strobe.rdSrc = RD_NONE;
    if (priSel && wrStb) begin
      unique case (regAddr)
        A_DATA:    strobe.bufWr    = drq;
        A_ERRFEAT: strobe.wrFeat   = 1'b1;
        A_SCNT:    strobe.wrSecCnt = 1'b1;
        A_LBA0:    strobe.wrLba0   = 1'b1;
        A_LBA1:    strobe.wrLba1   = 1'b1;
        A_LBA2:    strobe.wrLba2   = 1'b1;
        A_DRVHD:   strobe.wrDrvHd  = 1'b1;
        default:   ;
      endcase
    end
    if (secSel && wrStb && (regAddr == A_ALTCTL)) strobe.wrDevCtl = 1'b1;
    strobe.errAbort = cmdAccept && badCmd;
    strobe.errClear = cmdAccept && !badCmd;
    if (priSel && rdStb) begin
      unique case (regAddr)
        A_DATA:    strobe.rdSrc = drq ? RD_DATA : RD_ZERO;
        A_ERRFEAT: strobe.rdSrc = RD_ERROR;
        A_STATCMD: strobe.rdSrc = RD_STATUS;
        default:   strobe.rdSrc = RD_TASK;
      endcase
    end else if (secSel && rdStb) begin
      strobe.rdSrc = (regAddr == A_ALTCTL) ? RD_STATUS : RD_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bsy       <= 1'b0;
      drq       <= 1'b0;
      err       <= 1'b0;
      intPend   <= 1'b0;
      byteMode  <= 1'b0;
      xferCnt   <= '0;
      roleSlave <= slaveSel;
    end else begin
      if (statusRd) intPend <= 1'b0;
      if (cmdAccept) begin
        err     <= badCmd;
        intPend <= !isXfer;
        if (isXfer)     bsy      <= 1'b1;
        if (isByteFeat) byteMode <= 1'b1;
      end else if (bsy && cmdDone) begin
        bsy     <= 1'b0;
        drq     <= 1'b1;
        xferCnt <= '0;
        intPend <= 1'b1;
      end else if (dataAcc) begin
        if (lastAcc) drq <= 1'b0;
        else         xferCnt <= xferCnt + 1'b1;
      end
    end
  end

  assign statusByte = {bsy, 1'b1, 2'b00, drq, 2'b00, err};

endmodule

// File: rtl/ata_tf_dpath.sv
module ata_tf_dpath
  import ata_tf_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int BUS_W = 16,
  localparam int IDX_W = $clog2(SECTOR_BYTES),
  localparam int WIDX_W = IDX_W - 1,
  localparam int WORDS = SECTOR_BYTES / 2,
  localparam int LANES = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tfStrobe_t        strobe,
  input  logic [2:0]       regAddr,
  input  logic [BUS_W-1:0] dataIn,
  input  logic [7:0]       statusByte,
  input  logic             byteMode,
  input  logic [IDX_W-1:0] xferCnt,
  output logic [7:0]       featVal,
  output logic             drvHdSlave,
  output logic             intMask,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe
);

  logic [7:0] secCntR, lba0R, lba1R, lba2R, drvHdR, errR;
  logic [WIDX_W-1:0] wordIdx;
  logic laneSel;
  logic [LANES-1:0][7:0] laneData;
  logic [7:0] taskByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featVal <= '0;
      secCntR <= '0;
      lba0R   <= '0;
      lba1R   <= '0;
      lba2R   <= '0;
      drvHdR  <= '0;
      errR    <= '0;
      intMask <= 1'b0;
    end else begin
      if (strobe.wrFeat)   featVal <= dataIn[7:0];
      if (strobe.wrSecCnt) secCntR <= dataIn[7:0];
      if (strobe.wrLba0)   lba0R   <= dataIn[7:0];
      if (strobe.wrLba1)   lba1R   <= dataIn[7:0];
      if (strobe.wrLba2)   lba2R   <= dataIn[7:0];
      if (strobe.wrDrvHd)  drvHdR  <= dataIn[7:0];
      if (strobe.wrDevCtl) intMask <= dataIn[1];
      if (strobe.errAbort)      errR <= ERR_ABORT;
      else if (strobe.errClear) errR <= '0;
    end
  end

  assign drvHdSlave = drvHdR[4];
  assign wordIdx = byteMode ? xferCnt[IDX_W-1:1] : xferCnt[WIDX_W-1:0];
  assign laneSel = xferCnt[0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (strobe.bufWr && (!byteMode || (laneSel == g[0])))
        mem[wordIdx] <= byteMode ? dataIn[7:0] : dataIn[8*g +: 8];
    end
    assign laneData[g] = mem[wordIdx];
  end

  always_comb begin
    unique case (regAddr)
      A_SCNT:  taskByte = secCntR;
      A_LBA0:  taskByte = lba0R;
      A_LBA1:  taskByte = lba1R;
      A_LBA2:  taskByte = lba2R;
      A_DRVHD: taskByte = drvHdR;
      default: taskByte = '0;
    endcase
  end

  always_comb begin
    dataOut = '0;
    dataOe  = 1'b1;
    unique case (strobe.rdSrc)
      RD_DATA:   dataOut = byteMode ? BUS_W'(laneData[laneSel]) : laneData;
      RD_ERROR:  dataOut = BUS_W'(errR);
      RD_TASK:   dataOut = BUS_W'(taskByte);
      RD_STATUS: dataOut = BUS_W'(statusByte);
      RD_ZERO:   dataOut = '0;
      default:   dataOe  = 1'b0;
    endcase
  end

endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
  import ata_tf_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int BUS_W = 16,
  localparam int IDX_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csPriN,
  input  logic             csSecN,
  input  logic [2:0]       regAddr,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe,
  input  logic             slaveSel,
  input  logic             cmdDone,
  output logic             intrq,
  output logic             busyLed
);

  tfStrobe_t        strobe;
  logic [7:0]       statusByte;
  logic             byteMode;
  logic [IDX_W-1:0] xferCnt;
  logic             intPend;
  logic [7:0]       featVal;
  logic             drvHdSlave;
  logic             intMask;

  ata_tf_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csPriN(csPriN), .csSecN(csSecN),
    .regAddr(regAddr), .rdStb(rdStb), .wrStb(wrStb),
    .cmdByte(dataIn[7:0]), .slaveSel(slaveSel), .cmdDone(cmdDone),
    .featVal(featVal), .drvHdSlave(drvHdSlave), .strobe(strobe),
    .statusByte(statusByte), .byteMode(byteMode), .xferCnt(xferCnt),
    .intPend(intPend)
  );

  ata_tf_dpath #(.SECTOR_BYTES(SECTOR_BYTES), .BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .dataIn(dataIn), .statusByte(statusByte), .byteMode(byteMode),
    .xferCnt(xferCnt), .featVal(featVal), .drvHdSlave(drvHdSlave),
    .intMask(intMask), .dataOut(dataOut), .dataOe(dataOe)
  );

  assign intrq   = intPend && !intMask;
  assign busyLed = statusByte[7];

endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csPriN,
  input logic       csSecN,
  input logic [2:0] regAddr,
  input logic       rdStb,
  input logic       dataOe,
  input logic       cmdDone,
  input logic [7:0] statusByte,
  input logic       intPend
);

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csPriN && csSecN) |-> !dataOe);

  p_no_drive_without_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |-> !dataOe);

  p_bsy_drq_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3]));

  p_done_opens_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && cmdDone) |=> (statusByte[3] && !statusByte[7] && intPend));

  p_alt_read_keeps_int_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csPriN && !csSecN && regAddr == 3'd6 && rdStb && intPend) |=> intPend);

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && !cmdDone) |=> statusByte[7]);

endmodule

bind ata_taskfile_dev ata_tf_checker u_chk (
  .clk(clk), .rstN(rstN), .csPriN(csPriN), .csSecN(csSecN),
  .regAddr(regAddr), .rdStb(rdStb), .dataOe(dataOe), .cmdDone(cmdDone),
  .statusByte(statusByte), .intPend(intPend)
);

// File: tb/sim_ata_taskfile_dev.sv
module sim_ata_taskfile_dev;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csPriN = 1'b1, csSecN = 1'b1;
  logic [2:0]  regAddr = '0;
  logic        rdStb = 1'b0, wrStb = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic        slaveSel = 1'b0;
  logic        cmdDone = 1'b0;
  logic        intrq, busyLed;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ata_taskfile_dev u0 (
    .clk(clk), .rstN(rstN), .csPriN(csPriN), .csSecN(csSecN),
    .regAddr(regAddr), .rdStb(rdStb), .wrStb(wrStb), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .slaveSel(slaveSel),
    .cmdDone(cmdDone), .intrq(intrq), .busyLed(busyLed)
  );

  // vector: {isRead, isSec, addr[2:0], wdata[7:0], expected[7:0]}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd2, 8'hA5, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h3C, 8'h00},
    {1'b0, 1'b0, 3'd4, 8'h81, 8'h00},
    {1'b0, 1'b0, 3'd5, 8'h7E, 8'h00},
    {1'b0, 1'b0, 3'd6, 8'hE0, 8'h00},
    {1'b1, 1'b0, 3'd2, 8'h00, 8'hA5},
    {1'b1, 1'b0, 3'd3, 8'h00, 8'h3C},
    {1'b1, 1'b0, 3'd4, 8'h00, 8'h81},
    {1'b1, 1'b0, 3'd5, 8'h00, 8'h7E},
    {1'b1, 1'b0, 3'd6, 8'h00, 8'hE0},
    {1'b1, 1'b0, 3'd7, 8'h00, 8'h40},
    {1'b1, 1'b1, 3'd6, 8'h00, 8'h40},
    {1'b1, 1'b1, 3'd0, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd1, 8'h12, 8'h00},
    {1'b1, 1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 1'b0, 3'd2, 8'h00, 8'hA5}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input bit sec, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    csPriN = sec; csSecN = !sec; regAddr = a; dataIn = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; csPriN = 1'b1; csSecN = 1'b1;
  endtask

  task automatic busRd(input bit sec, input logic [2:0] a, output logic [15:0] d,
                       output logic oe);
    @(negedge clk);
    csPriN = sec; csSecN = !sec; regAddr = a; rdStb = 1'b1;
    #1;
    d = dataOut; oe = dataOe;
    @(negedge clk);
    rdStb = 1'b0; csPriN = 1'b1; csSecN = 1'b1;
  endtask

  task automatic pulseDone();
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
  endtask

  task automatic doReset(input logic role);
    @(negedge clk); slaveSel = role; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    logic [15:0] rd;
    logic oe;
    slaveSel = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    @(negedge clk); #1;
    chk("R1 idle oe", 16'(dataOe), 16'h0);
    chk("R4 idle led", 16'(busyLed), 16'h0);
    busRd(0, 3'd7, rd, oe);
    chk("R4 status after reset", rd, 16'h0040);
    chk("R1 oe on selected read", 16'(oe), 16'h1);
    busRd(0, 3'd6, rd, oe);
    chk("R2 drive/head after reset", rd, 16'h0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        busRd(VEC[i][19], VEC[i][18:16], rd, oe);
        chk($sformatf("R2/R3 vector %0d", i), rd, {8'h00, VEC[i][7:0]});
      end else begin
        busWr(VEC[i][19], VEC[i][18:16], {8'h00, VEC[i][15:8]});
      end
    end

    // R1 read strobe with no select
    @(negedge clk); rdStb = 1'b1; #1;
    chk("R1 deselected read oe", 16'(dataOe), 16'h0);
    @(negedge clk); rdStb = 1'b0;

    // R12 data read outside DRQ
    busRd(0, 3'd0, rd, oe);
    chk("R12 data outside DRQ", rd, 16'h0000);
    busRd(1, 3'd2, rd, oe);
    chk("R12 unmapped secondary", rd, 16'h0000);

    // R5 role mismatch: drive/head says slave, device is master
    busWr(0, 3'd6, 16'h00F0);
    busWr(0, 3'd7, 16'h0020);
    busRd(0, 3'd7, rd, oe);
    chk("R5 mismatched command ignored", rd, 16'h0040);
    chk("R5 no interrupt", 16'(intrq), 16'h0);
    busWr(0, 3'd6, 16'h00E0);

    // R7 unknown command, R10 alt vs status read
    busWr(0, 3'd7, 16'h0055);
    busRd(1, 3'd6, rd, oe);
    chk("R7 ERR in alt status", rd, 16'h0041);
    chk("R10 alt read keeps intrq", 16'(intrq), 16'h1);
    busRd(0, 3'd1, rd, oe);
    chk("R7 abort code", rd, 16'h0004);
    busRd(0, 3'd7, rd, oe);
    chk("R10 status read value", rd, 16'h0041);
    @(negedge clk);
    chk("R10 status read clears intrq", 16'(intrq), 16'h0);

    // R10 mask
    busWr(1, 3'd6, 16'h0002);
    busWr(0, 3'd7, 16'h0055);
    @(negedge clk);
    chk("R10 masked intrq", 16'(intrq), 16'h0);
    busWr(1, 3'd6, 16'h0000);
    @(negedge clk);
    chk("R10 unmasked intrq", 16'(intrq), 16'h1);
    busRd(0, 3'd7, rd, oe);

    // R8 write sector, 16-bit
    busWr(0, 3'd7, 16'h0030);
    busRd(0, 3'd7, rd, oe);
    chk("R8 busy after write-sector", rd, 16'h00C0);
    chk("R4 led while busy", 16'(busyLed), 16'h1);
    busRd(0, 3'd1, rd, oe);
    chk("R7 good command clears error", rd, 16'h0000);
    busWr(0, 3'd7, 16'h0055);
    busRd(0, 3'd7, rd, oe);
    chk("R11 command ignored while busy", rd, 16'h00C0);
    pulseDone();
    busRd(1, 3'd6, rd, oe);
    chk("R8 DRQ after done", rd, 16'h0048);
    chk("R8 interrupt after done", 16'(intrq), 16'h1);
    busRd(0, 3'd7, rd, oe);
    busWr(0, 3'd7, 16'h0055);
    busRd(0, 3'd7, rd, oe);
    chk("R11 command ignored while DRQ", rd, 16'h0048);
    for (int k = 0; k < 256; k++) begin
      if (k == 255) begin
        busRd(1, 3'd6, rd, oe);
        chk("R9 DRQ held before last word", rd, 16'h0048);
      end
      busWr(0, 3'd0, {8'(k) ^ 8'h5A, 8'(k)});
    end
    busRd(1, 3'd6, rd, oe);
    chk("R9 DRQ clear after 256 words", rd, 16'h0040);

    // R9 read back as words
    busWr(0, 3'd7, 16'h0020);
    pulseDone();
    busRd(0, 3'd7, rd, oe);
    for (int k = 0; k < 256; k++) begin
      busRd(0, 3'd0, rd, oe);
      chk($sformatf("R9 word %0d", k), rd, {8'(k) ^ 8'h5A, 8'(k)});
    end
    busRd(0, 3'd7, rd, oe);
    chk("R9 word read window closed", rd, 16'h0040);

    // R6 switch to bytes
    busWr(0, 3'd1, 16'h0001);
    busWr(0, 3'd7, 16'h00EF);
    busRd(0, 3'd7, rd, oe);
    chk("R6 set features completes", rd, 16'h0040);
    busWr(0, 3'd7, 16'h0020);
    pulseDone();
    for (int b = 0; b < 512; b++) begin
      if (b == 511) begin
        busRd(1, 3'd6, rd, oe);
        chk("R9 DRQ held before last byte", rd, 16'h0048);
      end
      busRd(0, 3'd0, rd, oe);
      chk($sformatf("R6/R9 byte %0d", b), rd,
          {8'h00, (b % 2 == 0) ? 8'(b / 2) : (8'(b / 2) ^ 8'h5A)});
    end
    busRd(1, 3'd6, rd, oe);
    chk("R9 DRQ clear after 512 bytes", rd, 16'h0040);

    // R7 set features with another code aborts
    busWr(0, 3'd1, 16'h0003);
    busWr(0, 3'd7, 16'h00EF);
    busRd(0, 3'd7, rd, oe);
    chk("R7 unsupported feature aborts", rd, 16'h0041);

    // R5 jumper change while running has no effect
    @(negedge clk); slaveSel = 1'b1;
    busWr(0, 3'd7, 16'h0020);
    busRd(0, 3'd7, rd, oe);
    chk("R5 role unchanged while running", rd, 16'h00C0);
    pulseDone();
    for (int b = 0; b < 512; b++) busRd(0, 3'd0, rd, oe);

    // R5/R6 reset as slave
    doReset(1'b1);
    busWr(0, 3'd7, 16'h0055);
    busRd(0, 3'd7, rd, oe);
    chk("R5 master-addressed command ignored by slave", rd, 16'h0040);
    busWr(0, 3'd6, 16'h00F0);
    busWr(0, 3'd7, 16'h0020);
    pulseDone();
    busRd(0, 3'd0, rd, oe);
    chk("R6 16-bit after reset", rd, 16'h5A00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule